// File: doc/BRIEF.md
# Cascadable 4-bit ALU slice

A purely combinational arithmetic and logic slice that works on two 4-bit operands. A 4-bit select together with a mode bit picks one of 32 functions. With the mode bit high, the carry chain is disabled and one of the 16 Boolean functions of two variables is applied bit by bit. With the mode bit low, the slice adds two per-bit operand terms that the select chooses, plus an active-low carry-in. Subtraction is one's-complement: the complement of B is formed inside the slice, and a carry-in turns A-B-1 into A-B.

Slices can be chained in two ways. The active-low carry-out of one slice can feed the carry-in of the next. The active-low group propagate and generate outputs can instead drive a separate lookahead unit. An all-ones detector on the result works as an equality flag when the slice is set to subtract with no carry-in. The carry-out then gives the relative magnitude of the operands.

Top module: `alu4_slice`

## Requirements
- R1: With mode_i=1 the result is bitwise, by sel_i value 0..15: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A. In this mode carry_n_i has no effect on res_o.
- R2: With mode_i=0, res_o is the low 4 bits of U+V+c. c is 1 when carry_n_i=0 and 0 when carry_n_i=1. U and V depend on sel_i: 0:(A,0) 1:(A|B,0) 2:(A|~B,0) 3:(15,0) 4:(A,A&~B) 5:(A|B,A&~B) 6:(A,~B) 7:(A&~B,15) 8:(A,A&B) 9:(A,B) 10:(A|~B,A&B) 11:(A&B,15) 12:(A,A) 13:(A|B,A) 14:(A|~B,A) 15:(A,15).
- R3: sel_i=6 with mode_i=0 gives A-B-1 mod 16 when carry_n_i=1, and A-B mod 16 when carry_n_i=0.
- R4: In both modes, cout_n_o is the inverse of bit 4 of the 5-bit sum U+V+c from R2.
- R5: Under sel_i=6, mode_i=0, cout_n_o is low exactly when A>B if carry_n_i=1, and exactly when A>=B if carry_n_i=0.
- R6: eq_o is high exactly when res_o equals 4'b1111. Under sel_i=6, mode_i=0 and carry_n_i=1, this happens exactly when A equals B.
- R7: gen_n_o is low exactly when U+V>=16. prop_n_o is low when U+V equals 15 and high when U+V is below 15. Together they satisfy ~cout_n_o == ~gen_n_o | (~prop_n_o & ~carry_n_i).
- R8: Four slices chained low to high through carry_n_i/cout_n_o give the 16-bit sum A+B with sel_i=9, carry_n_i=1. With sel_i=6, carry_n_i=0 they give the difference A-B, and the top carry-out is low exactly when A>=B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 4 | Operand A |
| opb_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select |
| mode_i | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_n_i | input | 1 | Carry-in, active low |
| res_o | output | 4 | Result |
| cout_n_o | output | 1 | Ripple carry-out, active low |
| prop_n_o | output | 1 | Group propagate, active low |
| gen_n_o | output | 1 | Group generate, active low |
| eq_o | output | 1 | High when the result is all ones |

## Verification
The slice has no parameters, so the bench builds it at its one fixed 4-bit width. It also builds a 16-bit chain of four copies. At this width every combination of operands, select, mode and carry-in can be tried: 2^14 points, each compared against a model taken from the requirements. Through the chain, ripple carry across slice boundaries and the 16-bit magnitude result can be checked on random and extreme operands.

// File: rtl/alu4_slice.sv
module alu4_slice (
  input  logic [3:0] opa_i,
  input  logic [3:0] opb_i,
  input  logic [3:0] sel_i,
  input  logic       mode_i,
  input  logic       carry_n_i,
  output logic [3:0] res_o,
  output logic       cout_n_o,
  output logic       prop_n_o,
  output logic       gen_n_o,
  output logic       eq_o
);
  logic [3:0] xt, yt;
  logic [4:0] c;
  logic       grp_g, grp_p;

  assign xt = opa_i | (opb_i & {4{sel_i[0]}}) | (~opb_i & {4{sel_i[1]}});
  assign yt = (opa_i & opb_i & {4{sel_i[3]}}) | (opa_i & ~opb_i & {4{sel_i[2]}});

  assign c[0] = ~carry_n_i;
  for (genvar i = 0; i < 4; i++) begin : g_rip
    assign c[i+1] = yt[i] | (xt[i] & c[i]);
  end

  assign grp_g = yt[3] | (xt[3] & yt[2]) | (xt[3] & xt[2] & yt[1])
               | (xt[3] & xt[2] & xt[1] & yt[0]);
  assign grp_p = &xt;

  assign res_o    = mode_i ? ~(xt ^ yt) : (xt ^ yt ^ c[3:0]);
  assign cout_n_o = ~(grp_g | (grp_p & c[0]));
  assign prop_n_o = ~grp_p;
  assign gen_n_o  = ~grp_g;
  assign eq_o     = &res_o;
endmodule

module alu4_slice_chk (
  input logic [3:0] opa_i,
  input logic [3:0] opb_i,
  input logic [3:0] sel_i,
  input logic       mode_i,
  input logic       carry_n_i,
  input logic [3:0] res_o,
  input logic       cout_n_o,
  input logic       prop_n_o,
  input logic       gen_n_o,
  input logic       eq_o
);
  logic [4:0] add5, sub5;
  assign add5 = {1'b0, opa_i} + {1'b0, opb_i} + {4'b0, ~carry_n_i};
  assign sub5 = {1'b0, opa_i} + {1'b0, ~opb_i} + {4'b0, ~carry_n_i};

  always_comb begin
    AST_LOOKAHEAD: assert (~cout_n_o == (~gen_n_o | (~prop_n_o & ~carry_n_i))); // R7
    if (!mode_i && sel_i == 4'd9) begin
      AST_ADD_SUM: assert ({~cout_n_o, res_o} == add5); // R2
    end
    if (!mode_i && sel_i == 4'd6) begin
      AST_SUB_DIFF: assert (res_o == sub5[3:0]); // R3
      AST_SUB_MAG: assert (~cout_n_o == (carry_n_i ? (opa_i > opb_i) : (opa_i >= opb_i))); // R5
      if (carry_n_i) begin
        AST_SUB_EQ: assert (eq_o == (opa_i == opb_i)); // R6
      end
    end
    if (mode_i && sel_i == 4'd6) begin
      AST_LOGIC_XOR: assert (res_o == (opa_i ^ opb_i)); // R1
    end
  end
endmodule

bind alu4_slice alu4_slice_chk u_chk (.*);

// File: tb/alu4_slice_tb.sv
module alu4_chain16 (
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic [3:0]  sel,
  input  logic        cin_n,
  output logic [15:0] f,
  output logic        cout_n
);
  logic [4:0] cc;
  assign cc[0] = cin_n;
  for (genvar k = 0; k < 4; k++) begin : g_sl
    logic pn, gn, eqk;
    alu4_slice u_s (
      .opa_i(a[4*k+:4]), .opb_i(b[4*k+:4]), .sel_i(sel), .mode_i(1'b0),
      .carry_n_i(cc[k]), .res_o(f[4*k+:4]), .cout_n_o(cc[k+1]),
      .prop_n_o(pn), .gen_n_o(gn), .eq_o(eqk));
  end
  assign cout_n = cc[4];
endmodule

module alu4_slice_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] a, b, s, f;
  logic m, cn, co, pn, gn, eq;
  int total = 0, fails = 0;

  alu4_slice u_dut (.opa_i(a), .opb_i(b), .sel_i(s), .mode_i(m), .carry_n_i(cn),
                    .res_o(f), .cout_n_o(co), .prop_n_o(pn), .gen_n_o(gn), .eq_o(eq));

  logic [15:0] wa, wb, wf;
  logic [3:0]  ws;
  logic        wcn, wco;
  alu4_chain16 u_chain (.a(wa), .b(wb), .sel(ws), .cin_n(wcn), .f(wf), .cout_n(wco));

  // {sel, mode, carry_n, a, b, expected res, expected cout_n}
  localparam logic [18:0] VEC [12] = '{
    {4'h9,1'b0,1'b1,4'h5,4'h3,4'h8,1'b1},
    {4'h9,1'b0,1'b0,4'hF,4'h1,4'h1,1'b0},
    {4'h6,1'b0,1'b1,4'h7,4'h3,4'h3,1'b0},
    {4'h6,1'b0,1'b0,4'h3,4'h7,4'hC,1'b1},
    {4'h0,1'b0,1'b0,4'hF,4'h0,4'h0,1'b0},
    {4'hF,1'b0,1'b1,4'h0,4'h5,4'hF,1'b1},
    {4'h3,1'b0,1'b0,4'h9,4'h4,4'h0,1'b0},
    {4'hC,1'b0,1'b1,4'h9,4'h0,4'h2,1'b0},
    {4'h6,1'b1,1'b1,4'hC,4'hA,4'h6,1'b0},
    {4'hB,1'b1,1'b0,4'hC,4'hA,4'h8,1'b0},
    {4'h0,1'b1,1'b1,4'h3,4'h0,4'hC,1'b1},
    {4'hE,1'b1,1'b1,4'h1,4'h2,4'h3,1'b1}
  };

  function automatic logic [3:0] logic_ref(input logic [3:0] sv, input logic [3:0] x, input logic [3:0] y);
    case (sv)
      4'd0: return ~x;        4'd1: return ~(x | y);
      4'd2: return ~x & y;    4'd3: return 4'h0;
      4'd4: return ~(x & y);  4'd5: return ~y;
      4'd6: return x ^ y;     4'd7: return x & ~y;
      4'd8: return ~x | y;    4'd9: return ~(x ^ y);
      4'd10: return y;        4'd11: return x & y;
      4'd12: return 4'hF;     4'd13: return x | ~y;
      4'd14: return x | y;    default: return x;
    endcase
  endfunction

  function automatic logic [7:0] opnds(input logic [3:0] sv, input logic [3:0] x, input logic [3:0] y);
    case (sv)
      4'd0: return {x, 4'h0};         4'd1: return {x | y, 4'h0};
      4'd2: return {x | ~y, 4'h0};    4'd3: return {4'hF, 4'h0};
      4'd4: return {x, x & ~y};       4'd5: return {x | y, x & ~y};
      4'd6: return {x, ~y};           4'd7: return {x & ~y, 4'hF};
      4'd8: return {x, x & y};        4'd9: return {x, y};
      4'd10: return {x | ~y, x & y};  4'd11: return {x & y, 4'hF};
      4'd12: return {x, x};           4'd13: return {x | y, x};
      4'd14: return {x | ~y, x};      default: return {x, 4'hF};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h s=%h m=%b cn=%b)", req, act, exp, a, b, s, m, cn);
    end
  endtask

  initial begin
    #3_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] uv;
    logic [4:0] s0, sum;
    logic [3:0] ef;
    logic [31:0] lcg;
    logic [16:0] ws17;
    a = 0; b = 0; s = 0; m = 0; cn = 1;
    wa = 0; wb = 0; ws = 4'h9; wcn = 1'b1;
    @(negedge clk);
    // initial state: all-zero inputs in arithmetic mode pass A=0 (R2)
    chk(f == 4'h0 && co == 1'b1 && eq == 1'b0, "R2 idle", {f, co, eq}, {4'h0, 1'b1, 1'b0});

    for (int i = 0; i < 12; i++) begin
      @(posedge clk);
      {s, m, cn, a, b} = VEC[i][18:5];
      @(negedge clk);
      chk(f == VEC[i][4:1], m ? "R1 vec res" : "R2 vec res", f, VEC[i][4:1]);
      chk(co == VEC[i][0], "R4 vec cout", co, VEC[i][0]);
    end

    for (int n = 0; n < 16384; n++) begin
      @(posedge clk);
      {s, m, cn, a, b} = n[13:0];
      @(negedge clk);
      uv  = opnds(s, a, b);
      s0  = {1'b0, uv[7:4]} + {1'b0, uv[3:0]};
      sum = s0 + {4'b0, ~cn};
      ef  = m ? logic_ref(s, a, b) : sum[3:0];
      chk(f == ef, m ? "R1 exhaustive" : "R2 exhaustive", f, ef);
      chk(co == ~sum[4], "R4 exhaustive", co, ~sum[4]);
      chk(eq == (f == 4'hF), "R6 flag", eq, (f == 4'hF));
      chk(gn == !(s0 >= 5'd16), "R7 generate", gn, !(s0 >= 5'd16));
      if (s0 <= 5'd15)
        chk(pn == (s0 != 5'd15), "R7 propagate", pn, (s0 != 5'd15));
      if (!m && s == 4'd6) begin
        ef = a - b - {3'b0, cn};
        chk(f == ef, "R3 subtract", f, ef);
        chk(co == !(cn ? (a > b) : (a >= b)), "R5 magnitude", co, !(cn ? (a > b) : (a >= b)));
        if (cn) chk(eq == (a == b), "R6 equality", eq, (a == b));
      end
    end

    // R1: carry-in ignored in logic mode at corner operands
    @(posedge clk); s = 4'd9; m = 1'b1; a = 4'hF; b = 4'hF; cn = 1'b0;
    @(negedge clk); ef = f;
    @(posedge clk); cn = 1'b1;
    @(negedge clk);
    chk(f == ef && f == 4'hF, "R1 carry ignored", f, 4'hF);

    lcg = 32'h1234_5678;
    for (int t = 0; t < 400; t++) begin
      @(posedge clk);
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (t == 0) begin wa = 16'hFFFF; wb = 16'h0001; end
      else if (t == 1) begin wa = 16'h8000; wb = 16'h8000; end
      else if (t == 2) begin wa = 16'h1234; wb = 16'h1234; end
      else begin wa = lcg[31:16]; wb = lcg[15:0]; end
      if (t[0]) begin ws = 4'h6; wcn = 1'b0; end else begin ws = 4'h9; wcn = 1'b1; end
      @(negedge clk);
      if (t[0]) begin
        chk(wf == wa - wb, "R8 diff", wf, wa - wb);
        chk(wco == !(wa >= wb), "R8 magnitude", wco, !(wa >= wb));
      end else begin
        ws17 = {1'b0, wa} + {1'b0, wb};
        chk({~wco, wf} == ws17, "R8 sum", {~wco, wf}, ws17);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule